// File: doc/BRIEF.md
# Per-Core Local Address Alias Translator

Each processor core in a multi-core device can reach its own local memory through a short alias window. In that window the top address byte is zero. This block sits between one core and the shared interconnect. It turns such an alias into the unique global address of that core's local memory. The same software image can then run unmodified on every core, while the interconnect only ever sees global addresses.

A request is treated as local when all three of these hold:

- it comes from a core;
- its top byte is zero;
- the instance's static core index is legal.

The top byte of a local request is then rewritten to a fixed global nibble followed by the core index. All other requests leave the block unchanged.

An illegal core index raises a configuration error and disables all rewriting. The block is combinational, with an optional output register controlled by a parameter. The default build has one register stage.

Top module: `core_alias_xlate`

## Requirements
- R1: A valid request with `src_is_core`=1, address bits [31:24] equal to 0x00 and `core_idx` below NUM_CORES (3) produces `out_aliased`=1.
- R2: For an aliased request, output bits [31:28] equal 4'h1 and bits [27:24] equal `core_idx`. Core 0 maps 0x00800000 to 0x10800000, core 1 to 0x11800000 and core 2 to 0x12800000.
- R3: Address bits [23:0] always reach the output unchanged.
- R4: A request whose bits [31:24] are not 0x00 leaves with its full address unchanged and `out_aliased`=0.
- R5: A request with `src_is_core`=0 leaves with its full address unchanged and `out_aliased`=0, whatever its top byte.
- R6: When `core_idx` is 3 or more, `cfg_err` is 1 and no address is rewritten. When `core_idx` is below 3, `cfg_err` is 0.
- R7: With REG_OUT=1, `out_addr`, `out_valid`, `out_aliased` and `cfg_err` all appear exactly one clock after the inputs are sampled. With REG_OUT=0 they follow the inputs in the same cycle.
- R8: `out_aliased` is 0 whenever `out_valid` is 0, and `out_valid` copies `req_valid` with the R7 latency.
- R9: After reset, and before the first request, `out_valid`, `out_aliased` and `cfg_err` are 0 and `out_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_idx | input | 4 | Static index of the core this instance serves |
| src_is_core | input | 1 | 1 when the request comes from the core, 0 for any other master |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| out_valid | output | 1 | Translated request strobe |
| out_addr | output | 32 | Global address sent to the interconnect |
| out_aliased | output | 1 | 1 when the top byte was rewritten |
| cfg_err | output | 1 | Illegal core index |

## Verification
The hardest case to reach is the corner where a zero top byte arrives from a core whose index is illegal. Normal traffic never combines a zero top byte with a bad index, so a directed test rarely lands there. The stimulus therefore sweeps every combination: all sixteen index values, both source kinds, and all 256 top-byte values. The low 24 bits are scrambled from the loop counters, and `req_valid` is dropped on a fixed subset of vectors. This puts the illegal-index-with-alias case, the invalid-strobe case and the non-core case each in front of the checks many times. Back-to-back vectors expose any slip in the one-cycle latency.

// File: rtl/alias_pkg.sv
package alias_pkg;
    parameter int unsigned AP_ADDR_W   = 32;
    parameter int unsigned AP_TOP_W    = 8;
    parameter int unsigned AP_IDX_W    = 4;
    parameter int unsigned AP_CORES    = 3;
    parameter logic [3:0]  AP_GLOBAL_NIB = 4'h1;
endpackage

// File: rtl/alias_decode.sv
module alias_decode #(
    parameter int unsigned TOP_W     = 8,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned NUM_CORES = 3
) (
    input  logic [TOP_W-1:0] top_byte,
    input  logic [IDX_W-1:0] idx,
    input  logic             from_core,
    output logic             idx_ok,
    output logic             is_local
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_CORES);

    always_comb begin
        idx_ok   = ({1'b0, idx} < LIMIT);
        is_local = from_core && (top_byte == '0) && idx_ok;
    end
endmodule

// File: rtl/alias_remap.sv
module alias_remap #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TOP_W  = 8,
    parameter int unsigned IDX_W  = 4,
    parameter logic [TOP_W-IDX_W-1:0] PREFIX = '0
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hit,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int unsigned LOW_W = ADDR_W - TOP_W;

    always_comb begin
        addr_out = addr_in;
        if (hit) begin
            addr_out[ADDR_W-1 -: TOP_W] = {PREFIX, idx};
        end
    end
endmodule

// File: rtl/core_alias_xlate.sv
module core_alias_xlate
    import alias_pkg::*;
#(
    parameter int unsigned ADDR_W    = AP_ADDR_W,
    parameter int unsigned NUM_CORES = AP_CORES,
    parameter bit          REG_OUT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        core_idx,
    input  logic              src_is_core,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_aliased,
    output logic              cfg_err
);
    localparam int unsigned TOP_W  = AP_TOP_W;
    localparam int unsigned IDX_W  = AP_IDX_W;
    localparam int unsigned LOW_W  = ADDR_W - TOP_W;
    localparam int unsigned PFX_W  = TOP_W - IDX_W;
    localparam logic [PFX_W-1:0] PREFIX = PFX_W'(AP_GLOBAL_NIB);

    typedef struct packed {
        logic              valid;
        logic              aliased;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } xl_t;

    logic              idx_ok;
    logic              is_local;
    logic [ADDR_W-1:0] mapped;
    xl_t               stage_d;
    xl_t               stage_q;

    alias_decode #(
        .TOP_W     (TOP_W),
        .IDX_W     (IDX_W),
        .NUM_CORES (NUM_CORES)
    ) u_dec (
        .top_byte  (req_addr[ADDR_W-1 -: TOP_W]),
        .idx       (core_idx),
        .from_core (src_is_core),
        .idx_ok    (idx_ok),
        .is_local  (is_local)
    );

    alias_remap #(
        .ADDR_W (ADDR_W),
        .TOP_W  (TOP_W),
        .IDX_W  (IDX_W),
        .PREFIX (PREFIX)
    ) u_map (
        .addr_in  (req_addr),
        .idx      (core_idx),
        .hit      (is_local),
        .addr_out (mapped)
    );

    always_comb begin
        stage_d         = '0;
        stage_d.valid   = req_valid;
        stage_d.aliased = req_valid && is_local;
        stage_d.err     = !idx_ok;
        stage_d.addr    = mapped;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= stage_d;
                end
            end

            // R7: strobe appears one cycle later
            assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> out_valid);
            assert_idle_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid |=> !out_valid);
            assert_low_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> out_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0]));
            assert_noncore_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !src_is_core |=> (out_addr == $past(req_addr)) && !out_aliased);
            assert_err_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (core_idx >= 4'(NUM_CORES)) |=> cfg_err);
        end else begin : g_comb
            assign stage_q = stage_d;
        end
    endgenerate

    assign out_valid   = stage_q.valid;
    assign out_aliased = stage_q.aliased;
    assign cfg_err     = stage_q.err;
    assign out_addr    = stage_q.addr;

    assert_alias_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_aliased |-> out_addr[ADDR_W-1 -: PFX_W] == PREFIX);
    assert_err_no_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_aliased);
    assert_alias_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_aliased);
endmodule

// File: tb/sim_core_alias_xlate.sv
module sim_core_alias_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  core_idx = '0;
    logic        src_is_core = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_aliased;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_alias_xlate #(.ADDR_W(32), .NUM_CORES(3), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .core_idx(core_idx), .src_is_core(src_is_core),
        .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
        .out_addr(out_addr), .out_aliased(out_aliased), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 valid", 32'(out_valid), 0);
        chk("R9 aliased", 32'(out_aliased), 0);
        chk("R9 err", 32'(cfg_err), 0);
        chk("R9 addr", out_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {out_addr[30:0], out_valid}, 0);

        // R2: named examples for cores 0..2
        for (int c = 0; c < 3; c++) begin
            core_idx = 4'(c); src_is_core = 1'b1; req_valid = 1'b1; req_addr = 32'h0080_0000;
            #1 chk("R7 no early change", 32'(out_aliased), 0);
            @(negedge clk);
            chk("R2 example", out_addr, 32'h1080_0000 | (32'(c) << 24));
            chk("R1 example", 32'(out_aliased), 1);
            req_valid = 1'b0;
            @(negedge clk);
        end

        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 2; s++) begin
                for (int t = 0; t < 256; t++) begin
                    logic [23:0] lo;
                    logic        v;
                    logic        ok;
                    logic        hit;
                    logic [31:0] ea;
                    lo = 24'((t * 32'h0001_0101) ^ (i * 32'h0000_09E3) ^ (s != 0 ? 32'h5A5A5A : 32'h0));
                    v  = (t % 7) != 3;
                    ok = i < 3;
                    hit = (s == 1) && (t == 0) && ok;
                    ea = hit ? {4'h1, 4'(i), lo} : {8'(t), lo};
                    core_idx = 4'(i); src_is_core = s[0]; req_valid = v;
                    req_addr = {8'(t), lo};
                    @(negedge clk);
                    if (!ok)        chk("R6 addr unchanged", out_addr, {8'(t), lo});
                    else if (s == 0) chk("R5 addr unchanged", out_addr, {8'(t), lo});
                    else if (hit)   chk("R2 mapped", out_addr, ea);
                    else            chk("R4 addr unchanged", out_addr, ea);
                    chk("R3 low bits", 32'(out_addr[23:0]), 32'(lo));
                    chk("R6 err flag", 32'(cfg_err), 32'(!ok));
                    chk("R7 R8 valid", 32'(out_valid), 32'(v));
                    if (hit) chk("R1 aliased", 32'(out_aliased), 32'(v));
                    else     chk("R8 R4 R5 aliased", 32'(out_aliased), 0);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule